// File: doc/BRIEF.md
# Strap-Addressed Serial Register Slave

This block is the two-wire serial bus slave in front of a nine-entry bank of 8-bit control and status registers. The bus clock is an input only, because the slave never stretches it. The data line is driven open-drain through a single pull-low enable. Both lines are brought into the system clock by a two-flop synchroniser. Bit, START and STOP events are detected from the synchronised levels, so the system clock must run at least eight times faster than the 400 kHz bus.

Two strap inputs set the 7-bit bus address. Each strap can be tied to ground, to the logic supply, to the clock line or to the data line, and arrives already sensed as a 2-bit code. The upper four address bits are fixed at 1100; the strap pair chooses the lower three. When both straps are tied to ground, the bus is disabled and the block reports stand-alone mode.

A host first writes a register pointer. It then either writes data bytes to successive registers, or issues a repeated START and reads bytes from successive registers. The bank sees a write strobe carrying an index and a data byte. It also sees a one-cycle read strobe when each read byte is finished, which it can use for clear-on-read.

Top module: `strapI2cSlave`

## Requirements
- R1: The strap code per pin is 0 = ground, 1 = supply, 2 = clock line, 3 = data line. With combo = 4*strapA + strapB, combo 0 is stand-alone. Any other combo gives the 7-bit address {1100, low}, where low = ((combo-1) mod 7) + 1. For example, combo 6 answers to write byte 0xCC.
- R2: In stand-alone mode `standAlone` is 1 and the block never pulls the data line low, whatever the bus does. In every other mode `standAlone` is 0.
- R3: After a START, a first byte whose upper seven bits equal the strapped address is acknowledged. The data line is held low from the start to the end of the ninth clock-high phase. The block changes its drive only while the clock line is low.
- R4: A first byte that does not match gets no acknowledge. Until the next START, the following bytes get no acknowledge and produce no register write.
- R5: A write transaction sends the address with R/W = 0, then a pointer byte, then data bytes. Each data byte is acknowledged and gives a one-cycle `regWrEn` pulse, with `regIdx` equal to the pointer and `regWrData` equal to the byte. The pointer then advances by one.
- R6: A repeated START with R/W = 1 returns register bytes MSB first, starting at the pointer and advancing by one per byte. Output continues while the host acknowledges (data low). After a host not-acknowledge, the block releases the data line.
- R7: When the host's acknowledge bit for a read byte is clocked, whether ACK or NACK, `regRdStrobe` pulses for one cycle with `regIdx` equal to that byte's register.
- R8: Pointer values above 0x08 are acknowledged. Data written there is dropped (no `regWrEn`). Reads from there return 0x00 and give no `regRdStrobe`.
- R9: After a STOP, bus clocks without a new START get no acknowledge.
- R10: Out of reset, `sdaPullLow`, `regWrEn` and `regRdStrobe` are all 0. `regWrEn` and `regRdStrobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 pulls the data line low (open-drain enable) |
| strapA | input | 2 | Sensed code of the first address strap |
| strapB | input | 2 | Sensed code of the second address strap |
| standAlone | output | 1 | 1 when both straps are tied to ground |
| regIdx | output | 4 | Register index for access and strobes |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Bank contents at `regIdx` |
| regRdStrobe | output | 1 | One-cycle strobe when a read byte completes |

## Verification
The hardest state to reach from the ports is the one where the block has dropped off the bus but the bus keeps clocking. The stimulus reaches it in two ways. First, it sends a mismatching address and then clocks a full byte with no START. Second, it issues a STOP and then clocks an address byte with no START. In both cases it watches the data line during the ninth clock and counts write strobes. A second hard point is the end of a burst read, where the host's not-acknowledge must still produce a read strobe for the last register. Bursts that run from register 8 into the out-of-range area show the index at which the strobes stop.

// File: rtl/strapI2cPkg.sv
package strapI2cPkg;
  localparam int DATA_W = 8;
  localparam logic [3:0] ADDR_HI = 4'b1100;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLvl;
  } busEvT;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadPtr;
    logic writeByte;
    logic readDone;
  } strobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_TXACK, ST_TXEND
  } stateT;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kindT;
endpackage

// File: rtl/strapI2cAddr.sv
module strapI2cAddr
  import strapI2cPkg::*;
(
  input  logic [1:0] strapA,
  input  logic [1:0] strapB,
  output logic       standAlone,
  output logic [6:0] myAddr
);
  logic [3:0] combo;
  logic [3:0] offs;
  logic [2:0] low;

  assign combo = {strapA, strapB};

  always_comb begin
    offs = combo - 4'd1;
    if (offs >= 4'd14)     offs = offs - 4'd14;
    else if (offs >= 4'd7) offs = offs - 4'd7;
    low = offs[2:0] + 3'd1;
  end

  assign standAlone = (combo == 4'd0);
  assign myAddr     = {ADDR_HI, low};
endmodule

// File: rtl/strapI2cSync.sv
module strapI2cSync
  import strapI2cPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  sclIn,
  input  logic  sdaIn,
  output busEvT ev
);
  localparam int LINES = 2;
  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] curLvl;
  logic [LINES-1:0] prevLvl;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-1:0], rawLines[g]};
    end
    assign curLvl[g]  = pipe[SYNC_STAGES-1];
    assign prevLvl[g] = pipe[SYNC_STAGES];
  end

  // index 1 = clock line, index 0 = data line
  assign ev.sclRise   = curLvl[1] & ~prevLvl[1];
  assign ev.sclFall   = ~curLvl[1] & prevLvl[1];
  assign ev.startSeen = curLvl[1] & prevLvl[1] & prevLvl[0] & ~curLvl[0];
  assign ev.stopSeen  = curLvl[1] & prevLvl[1] & ~prevLvl[0] & curLvl[0];
  assign ev.sdaLvl    = curLvl[0];
endmodule

// File: rtl/strapI2cCtrl.sv
module strapI2cCtrl
  import strapI2cPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busEvT             ev,
  input  logic              standAlone,
  input  logic [6:0]        myAddr,
  input  logic [DATA_W-1:0] rxByte,
  output strobeT            stb,
  output logic              ackDrive,
  output logic              txActive
);
  localparam logic [2:0] LAST_BIT = 3'(DATA_W - 1);

  stateT      stQ, stNext;
  kindT       kindQ, kindNext;
  logic [2:0] cntQ, cntNext;
  logic       rwQ, rwNext;
  logic       ackdQ, ackdNext;

  always_comb begin
    stNext   = stQ;
    kindNext = kindQ;
    cntNext  = cntQ;
    rwNext   = rwQ;
    ackdNext = ackdQ;
    stb      = '0;
    if (standAlone || ev.stopSeen) begin
      stNext = ST_IDLE;
    end else if (ev.startSeen) begin
      stNext   = ST_RX;
      kindNext = K_ADDR;
      cntNext  = '0;
    end else begin
      unique case (stQ)
        ST_RX: if (ev.sclRise) begin
          stb.shiftIn = 1'b1;
          if (cntQ == LAST_BIT) stNext = ST_RXEND;
          else                  cntNext = cntQ + 3'd1;
        end
        ST_RXEND: if (ev.sclFall) begin
          unique case (kindQ)
            K_ADDR: begin
              if (rxByte[DATA_W-1:1] == myAddr) begin
                rwNext = rxByte[0];
                stNext = ST_ACK;
              end else begin
                stNext = ST_IDLE;
              end
            end
            K_PTR: begin
              stb.loadPtr = 1'b1;
              stNext      = ST_ACK;
            end
            default: begin
              stb.writeByte = 1'b1;
              stNext        = ST_ACK;
            end
          endcase
        end
        ST_ACK: if (ev.sclFall) begin
          cntNext = '0;
          if (kindQ == K_ADDR && rwQ) begin
            stb.loadTx = 1'b1;
            stNext     = ST_TX;
          end else begin
            kindNext = (kindQ == K_ADDR) ? K_PTR : K_DATA;
            stNext   = ST_RX;
          end
        end
        ST_TX: if (ev.sclFall) begin
          if (cntQ == LAST_BIT) begin
            stNext = ST_TXACK;
          end else begin
            stb.shiftOut = 1'b1;
            cntNext      = cntQ + 3'd1;
          end
        end
        ST_TXACK: if (ev.sclRise) begin
          stb.readDone = 1'b1;
          ackdNext     = ~ev.sdaLvl;
          stNext       = ST_TXEND;
        end
        ST_TXEND: if (ev.sclFall) begin
          if (ackdQ) begin
            stb.loadTx = 1'b1;
            cntNext    = '0;
            stNext     = ST_TX;
          end else begin
            stNext = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      kindQ <= K_ADDR;
      cntQ  <= '0;
      rwQ   <= 1'b0;
      ackdQ <= 1'b0;
    end else begin
      stQ   <= stNext;
      kindQ <= kindNext;
      cntQ  <= cntNext;
      rwQ   <= rwNext;
      ackdQ <= ackdNext;
    end
  end

  assign ackDrive = (stQ == ST_ACK);
  assign txActive = (stQ == ST_TX);
endmodule

// File: rtl/strapI2cData.sv
module strapI2cData
  import strapI2cPkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeT                      stb,
  input  logic                        sdaLvl,
  input  logic [DATA_W-1:0]           regRdData,
  output logic [DATA_W-1:0]           rxByte,
  output logic                        txBit,
  output logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic                        regWrEn,
  output logic [DATA_W-1:0]           regWrData,
  output logic                        regRdStrobe
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] LAST_IDX = DATA_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] ptrQ;
  logic              bumpQ;
  logic              inRange;

  assign inRange = (ptrQ <= LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg       <= '0;
      ptrQ        <= '0;
      bumpQ       <= 1'b0;
      regWrEn     <= 1'b0;
      regWrData   <= '0;
      regRdStrobe <= 1'b0;
    end else begin
      bumpQ       <= stb.writeByte | stb.readDone;
      regWrEn     <= stb.writeByte & inRange;
      regRdStrobe <= stb.readDone & inRange;
      if (stb.writeByte) regWrData <= shReg;
      if (stb.loadPtr)    ptrQ <= shReg;
      else if (bumpQ)     ptrQ <= ptrQ + 1'b1;
      if (stb.shiftIn)       shReg <= {shReg[DATA_W-2:0], sdaLvl};
      else if (stb.loadTx)   shReg <= inRange ? regRdData : '0;
      else if (stb.shiftOut) shReg <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  assign rxByte = shReg;
  assign txBit  = shReg[DATA_W-1];
  assign regIdx = ptrQ[IDX_W-1:0];
endmodule

// File: rtl/strapI2cSlave.sv
module strapI2cSlave
  import strapI2cPkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaPullLow,
  input  logic [1:0]                  strapA,
  input  logic [1:0]                  strapB,
  output logic                        standAlone,
  output logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic                        regWrEn,
  output logic [DATA_W-1:0]           regWrData,
  input  logic [DATA_W-1:0]           regRdData,
  output logic                        regRdStrobe
);
  busEvT             ev;
  strobeT            stb;
  logic [6:0]        myAddr;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;
  logic              ackDrive;
  logic              txActive;

  strapI2cAddr i_addr (
    .strapA(strapA), .strapB(strapB),
    .standAlone(standAlone), .myAddr(myAddr)
  );

  strapI2cSync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  strapI2cCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .standAlone(standAlone),
    .myAddr(myAddr), .rxByte(rxByte), .stb(stb),
    .ackDrive(ackDrive), .txActive(txActive)
  );

  strapI2cData #(.NUM_REGS(NUM_REGS)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(ev.sdaLvl),
    .regRdData(regRdData), .rxByte(rxByte), .txBit(txBit),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdStrobe(regRdStrobe)
  );

  assign sdaPullLow = ackDrive | (txActive & ~txBit);
endmodule

// File: rtl/strapI2cChecker.sv
module strapI2cChecker #(
  parameter int NUM_REGS = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        sclIn,
  input logic                        standAlone,
  input logic                        sdaPullLow,
  input logic [$clog2(NUM_REGS)-1:0] regIdx,
  input logic                        regWrEn,
  input logic                        regRdStrobe
);
  a_r2_standalone_quiet: assert property (@(posedge clk) disable iff (!rstN)
    standAlone |=> !sdaPullLow);

  a_r3_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !standAlone && !$past(standAlone)) |-> !sclIn);

  a_r5_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regRdStrobe |=> !regRdStrobe);

  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (int'(regIdx) < NUM_REGS));

  a_r8_read_in_range: assert property (@(posedge clk) disable iff (!rstN)
    regRdStrobe |-> (int'(regIdx) < NUM_REGS));

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdStrobe));
endmodule

bind strapI2cSlave strapI2cChecker #(.NUM_REGS(NUM_REGS)) i_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .standAlone(standAlone),
  .sdaPullLow(sdaPullLow), .regIdx(regIdx), .regWrEn(regWrEn),
  .regRdStrobe(regRdStrobe)
);

// File: tb/test_strapI2cSlave.sv
module test_strapI2cSlave;
  localparam int QC = 8;
  // entry = {strapA, strapB, expected low address bits}; low 0 = stand-alone
  localparam logic [6:0] STRAP_TAB [16] = '{
    7'h00, 7'h09, 7'h12, 7'h1B, 7'h24, 7'h2D, 7'h36, 7'h3F,
    7'h41, 7'h4A, 7'h53, 7'h5C, 7'h65, 7'h6E, 7'h77, 7'h79
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow;
  logic [1:0] strapA = 2'd1;
  logic [1:0] strapB = 2'd2;
  logic standAlone;
  logic [3:0] regIdx;
  logic regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic regRdStrobe;

  logic [7:0] bank [0:8];
  int wrCount = 0;
  int rdCount = 0;
  int lastRdIdx = -1;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;
  assign regRdData = (regIdx < 4'd9) ? bank[regIdx] : 8'hA5;

  strapI2cSlave i_strapI2cSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .strapA(strapA), .strapB(strapB),
    .standAlone(standAlone), .regIdx(regIdx), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .regRdStrobe(regRdStrobe)
  );

  initial for (int i = 0; i < 9; i++) bank[i] = 8'h10 + 8'(i);

  always @(posedge clk) begin
    if (regWrEn) begin
      bank[regIdx] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdStrobe) begin
      rdCount <= rdCount + 1;
      lastRdIdx <= int'(regIdx);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QC) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // returns 1 = acked for the whole high phase, 0 = released throughout, 2 = mixed
  task automatic sendByte(input logic [7:0] b, output int ackState);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1;
    @(negedge clk); s1 = sdaLine;
    repeat (2*QC - 2) @(negedge clk);
    s2 = sdaLine;
    @(negedge clk);
    sclM = 1'b0; waitQ();
    if (!s1 && !s2)     ackState = 1;
    else if (s1 && s2)  ackState = 0;
    else                ackState = 2;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ();
      sclM = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      sclM = 1'b0; waitQ();
    end
    sendBit(~hostAck);
    sdaM = 1'b1;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int ack;
    int wr0, rd0;
    logic [7:0] rb;
    logic [2:0] low, wrong;

    repeat (5) @(negedge clk);
    check("R10 sdaPullLow in reset", int'(sdaPullLow), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 sdaPullLow after reset", int'(sdaPullLow), 0);
    check("R10 regWrEn after reset", int'(regWrEn), 0);
    check("R10 regRdStrobe after reset", int'(regRdStrobe), 0);

    // R1 / R2 / R3: strap table walk
    for (int i = 0; i < 16; i++) begin
      strapA = STRAP_TAB[i][6:5];
      strapB = STRAP_TAB[i][4:3];
      low    = STRAP_TAB[i][2:0];
      repeat (4) @(negedge clk);
      check($sformatf("R2 standAlone combo %0d", i), int'(standAlone), int'(low == 3'd0));
      if (low != 3'd0) begin
        busStart();
        sendByte({4'b1100, low, 1'b0}, ack);
        check($sformatf("R1 R3 ack own address combo %0d", i), ack, 1);
        busStop();
        wrong = (low == 3'd7) ? 3'd1 : low + 3'd1;
        busStart();
        sendByte({4'b1100, wrong, 1'b0}, ack);
        check($sformatf("R1 no ack other address combo %0d", i), ack, 0);
        busStop();
      end else begin
        for (int a = 1; a < 8; a++) begin
          busStart();
          sendByte({4'b1100, 3'(a), 1'b0}, ack);
          check($sformatf("R2 stand-alone silent addr %0d", a), ack, 0);
          busStop();
        end
      end
    end

    strapA = 2'd1; strapB = 2'd2;  // combo 6 -> write byte 0xCC
    repeat (4) @(negedge clk);

    // R5 burst write
    wr0 = wrCount;
    busStart();
    sendByte(8'hCC, ack);  check("R5 address ack", ack, 1);
    sendByte(8'h02, ack);  check("R5 pointer ack", ack, 1);
    sendByte(8'h11, ack);  check("R5 data ack 0", ack, 1);
    sendByte(8'h22, ack);  check("R5 data ack 1", ack, 1);
    sendByte(8'h33, ack);  check("R5 data ack 2", ack, 1);
    busStop();
    repeat (4) @(negedge clk);
    check("R5 reg2", int'(bank[2]), 8'h11);
    check("R5 reg3", int'(bank[3]), 8'h22);
    check("R5 reg4", int'(bank[4]), 8'h33);
    check("R5 reg5 untouched", int'(bank[5]), 8'h15);
    check("R5 write count", wrCount - wr0, 3);

    // R6 / R7 burst read
    rd0 = rdCount;
    busStart();
    sendByte(8'hCC, ack);
    sendByte(8'h02, ack);
    busStart();
    sendByte(8'hCD, ack);  check("R6 read address ack", ack, 1);
    recvByte(1'b1, rb);    check("R6 read byte 0", int'(rb), 8'h11);
    recvByte(1'b1, rb);    check("R6 read byte 1", int'(rb), 8'h22);
    recvByte(1'b0, rb);    check("R6 read byte 2", int'(rb), 8'h33);
    repeat (4) @(negedge clk);
    check("R6 released after NACK", int'(sdaPullLow), 0);
    busStop();
    check("R7 read strobe count", rdCount - rd0, 3);
    check("R7 last strobe index", lastRdIdx, 4);

    // R8 pointer past last register
    wr0 = wrCount;
    busStart();
    sendByte(8'hCC, ack);
    sendByte(8'h08, ack);
    sendByte(8'h77, ack);  check("R8 write reg8 ack", ack, 1);
    sendByte(8'h99, ack);  check("R8 write past end ack", ack, 1);
    busStop();
    check("R8 only in-range write", wrCount - wr0, 1);
    check("R8 reg8 value", int'(bank[8]), 8'h77);
    busStart();
    sendByte(8'hCC, ack);
    sendByte(8'h20, ack);  check("R8 far pointer ack", ack, 1);
    sendByte(8'h5A, ack);  check("R8 far data ack", ack, 1);
    busStop();
    check("R8 far write dropped", wrCount - wr0, 1);
    rd0 = rdCount;
    busStart();
    sendByte(8'hCC, ack);
    sendByte(8'h08, ack);
    busStart();
    sendByte(8'hCD, ack);
    recvByte(1'b1, rb);    check("R8 read reg8", int'(rb), 8'h77);
    recvByte(1'b0, rb);    check("R8 read past end zero", int'(rb), 0);
    busStop();
    check("R8 strobe only in range", rdCount - rd0, 1);
    check("R7 strobe index reg8", lastRdIdx, 8);

    // R4 mismatch then bytes without START
    wr0 = wrCount;
    busStart();
    sendByte(8'hC2, ack);  check("R4 mismatch nack", ack, 0);
    sendByte(8'h03, ack);  check("R4 ignored byte 1", ack, 0);
    sendByte(8'hCC, ack);  check("R4 ignored own address w/o START", ack, 0);
    busStop();
    check("R4 no writes", wrCount - wr0, 0);

    // R9 clocks after STOP without START
    busStart();
    sendByte(8'hCC, ack);
    sendByte(8'h01, ack);
    busStop();
    sendByte(8'hCC, ack);  check("R9 no ack after STOP", ack, 0);
    sendByte(8'h44, ack);  check("R9 no ack second byte", ack, 0);
    busStop();
    check("R9 no writes", wrCount - wr0, 0);
    check("R9 reg1 unchanged", int'(bank[1]), 8'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule